// File: doc/BRIEF.md
# Burst Read Output Pacer

This block is the output stage of a synchronous burst read on a 16-bit memory-like device. An internal source offers words with a valid strobe. The block places each accepted word on the data bus and keeps it there for one or two clock cycles, as a hold-length setting selects. It takes the next word only once the current word's hold has run out.

Alongside the data, the block drives a WAIT line that tells the host when no valid word is on the bus. Whether WAIT is driven or left floating depends on chip enable, output enable and the kind of access in progress. The hold-length setting is captured when a burst begins, which is when chip enable goes active. Taking chip enable inactive ends the burst at once.

Top module: `burst_pacer`

## Requirements
- R1: With the captured hold setting at 1 (long hold), each accepted word stays on `dq_o` for exactly two clock cycles. A word offered during the first of those two cycles is ignored, and the next word is taken on the edge that ends the second cycle.
- R2: With the captured hold setting at 0 (short hold), a continuously valid source has a new word on `dq_o` every cycle.
- R3: After reset the captured hold setting is long. A burst whose chip enable is already low as reset ends uses the two-cycle hold whatever `hold_long_i` is.
- R4: While `ce_ni` is high, `wait_oe_o` is 0 (WAIT floats) and `wait_o` is 0.
- R5: Access kind encoding on `rd_mode_i`: 0 = synchronous array read, 1 = synchronous non-array read, 2 = asynchronous read, 3 = write. With `ce_ni` low and `oe_ni` high, WAIT floats for kinds 0 and 1. For kinds 2 and 3 it is driven to 0.
- R6: With `ce_ni` and `oe_ni` both low, WAIT is driven (`wait_oe_o` = 1). For kinds 2 and 3 its value is 0.
- R7: With `ce_ni` and `oe_ni` both low and kind 0 or 1, `wait_o` is 1 exactly while no valid word is on the bus. It goes to 0 in the same cycle a word appears, and returns to 1 when a hold ends with no new word ready.
- R8: A source word offered while the current word's hold has not ended has no effect on `dq_o`.
- R9: `dq_oe_o` is 1 only while `ce_ni` and `oe_ni` are both low. `dq_o` is 0 whenever the bus is released or no valid word is held.
- R10: `hold_long_i` is captured only on the clock edge where `ce_ni` is first seen low. Changing it later in the burst does not change the hold length.
- R11: A cycle with `ce_ni` high clears the hold count and discards the held word. When chip enable returns with no source word, WAIT is asserted and `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_mode_i | input | 2 | Access kind (0 sync array, 1 sync non-array, 2 async, 3 write) |
| hold_long_i | input | 1 | Hold setting: 1 = two cycles per word, 0 = one cycle |
| src_valid_i | input | 1 | Source word valid strobe |
| src_data_i | input | 16 | Source word |
| dq_o | output | 16 | Data bus value |
| dq_oe_o | output | 1 | Data bus drive enable |
| wait_o | output | 1 | WAIT, active high |
| wait_oe_o | output | 1 | WAIT drive enable |

## Verification
The bench streams a new source word every cycle so that a pacer ignoring the hold would show each fresh word instead of repeating the held one, and one that extended the hold would lag the pattern. It flips the hold setting in the middle of a burst and brings the block out of reset with chip enable already low. A design that sampled the setting continually, or that lost the reset default, would then run the wrong hold length. It aborts a burst in the middle of a hold and re-enables with no source word: a design that kept the stale word would show old data with WAIT low. Finally it walks every access kind across the chip and output enable combinations, which catches a WAIT that floats when it should be driven low, or the reverse.

// File: rtl/burst_pacer_pkg.sv
package burst_pacer_pkg;

    typedef enum logic [1:0] {
        KIND_SYNC_ARRAY = 2'd0,
        KIND_SYNC_OTHER = 2'd1,
        KIND_ASYNC_RD   = 2'd2,
        KIND_WRITE      = 2'd3
    } access_kind_e;

    function automatic logic kind_is_sync(input access_kind_e k);
        return (k == KIND_SYNC_ARRAY) || (k == KIND_SYNC_OTHER);
    endfunction

endpackage

// File: rtl/burst_pacer_seq.sv
module burst_pacer_seq #(
    parameter int DATA_W     = 16,
    parameter int HOLD_LONG  = 2,
    parameter int HOLD_SHORT = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_act_i,
    input  logic              hold_long_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              hold_long_o,
    output logic              load_o
);
    localparam int CNT_W = $clog2(HOLD_LONG + 1);

    typedef struct packed {
        logic              ce_seen;
        logic              hold_long;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [DATA_W-1:0] word;
    } pacer_st_t;

    pacer_st_t st_q, st_d;
    logic      burst_start;
    logic      hold_eff;
    logic      load;

    always_comb begin
        st_d        = st_q;
        load        = 1'b0;
        burst_start = ce_act_i && !st_q.ce_seen;
        hold_eff    = burst_start ? hold_long_i : st_q.hold_long;
        st_d.ce_seen = ce_act_i;
        if (!ce_act_i) begin
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
            st_d.word  = '0;
        end else begin
            st_d.hold_long = hold_eff;
            if (st_q.cnt <= CNT_W'(1)) begin
                if (src_valid_i) begin
                    load       = 1'b1;
                    st_d.word  = src_data_i;
                    st_d.valid = 1'b1;
                    st_d.cnt   = hold_eff ? CNT_W'(HOLD_LONG) : CNT_W'(HOLD_SHORT);
                end else begin
                    st_d.cnt   = '0;
                    st_d.valid = 1'b0;
                    st_d.word  = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ce_seen   <= 1'b1;
            st_q.hold_long <= 1'b1;
            st_q.cnt       <= '0;
            st_q.valid     <= 1'b0;
            st_q.word      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o       = st_q.word;
    assign word_valid_o = st_q.valid;
    assign hold_long_o  = st_q.hold_long;
    assign load_o       = load;

endmodule

// File: rtl/burst_pacer_io.sv
module burst_pacer_io
    import burst_pacer_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              ce_act_i,
    input  logic              oe_act_i,
    input  access_kind_e      kind_i,
    input  logic              word_valid_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              wait_o,
    output logic              wait_oe_o
);
    logic sync_kind;

    always_comb begin
        sync_kind = kind_is_sync(kind_i);
        dq_oe_o   = ce_act_i && oe_act_i;
        dq_o      = (dq_oe_o && word_valid_i) ? word_i : '0;
        wait_oe_o = ce_act_i && (oe_act_i || !sync_kind);
        wait_o    = wait_oe_o && oe_act_i && sync_kind && !word_valid_i;
    end

endmodule

// File: rtl/burst_pacer.sv
module burst_pacer
    import burst_pacer_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int HOLD_LONG  = 2,
    parameter int HOLD_SHORT = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_ni,
    input  logic              oe_ni,
    input  logic [1:0]        rd_mode_i,
    input  logic              hold_long_i,
    input  logic              src_valid_i,
    input  logic [DATA_W-1:0] src_data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    output logic              wait_o,
    output logic              wait_oe_o
);
    logic              ce_act;
    logic              oe_act;
    logic [DATA_W-1:0] word;
    logic              word_valid;
    logic              hold_long_q;
    logic              load_w;
    access_kind_e      kind;

    assign ce_act = !ce_ni;
    assign oe_act = !oe_ni;
    assign kind   = access_kind_e'(rd_mode_i);

    burst_pacer_seq #(
        .DATA_W     (DATA_W),
        .HOLD_LONG  (HOLD_LONG),
        .HOLD_SHORT (HOLD_SHORT)
    ) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ce_act_i     (ce_act),
        .hold_long_i  (hold_long_i),
        .src_valid_i  (src_valid_i),
        .src_data_i   (src_data_i),
        .word_o       (word),
        .word_valid_o (word_valid),
        .hold_long_o  (hold_long_q),
        .load_o       (load_w)
    );

    burst_pacer_io #(
        .DATA_W (DATA_W)
    ) u_io (
        .ce_act_i     (ce_act),
        .oe_act_i     (oe_act),
        .kind_i       (kind),
        .word_valid_i (word_valid),
        .word_i       (word),
        .dq_o         (dq_o),
        .dq_oe_o      (dq_oe_o),
        .wait_o       (wait_o),
        .wait_oe_o    (wait_oe_o)
    );

endmodule

// File: rtl/burst_pacer_chk.sv
module burst_pacer_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ce_ni,
    input logic              oe_ni,
    input logic [1:0]        rd_mode_i,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe_o,
    input logic              wait_o,
    input logic              wait_oe_o,
    input logic              load_w,
    input logic              hold_long_q
);
    p_wait_float_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ce_ni |-> (!wait_oe_o && !wait_o));

    p_sync_oe_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && oe_ni && !rd_mode_i[1]) |-> !wait_oe_o);

    p_async_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_ni && rd_mode_i[1]) |-> (wait_oe_o && !wait_o));

    p_bus_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_ni || oe_ni) |-> (!dq_oe_o && dq_o == '0));

    p_long_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_w |=> (!hold_long_q || !load_w));

    p_wait_vs_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wait_o && dq_oe_o) |-> (dq_o == '0));

endmodule

bind burst_pacer burst_pacer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .rd_mode_i   (rd_mode_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o),
    .wait_o      (wait_o),
    .wait_oe_o   (wait_oe_o),
    .load_w      (load_w),
    .hold_long_q (hold_long_q)
);

// File: tb/burst_pacer_tb_top.sv
module burst_pacer_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        ce_ni = 1'b1;
    logic        oe_ni = 1'b1;
    logic [1:0]  rd_mode_i = 2'd0;
    logic        hold_long_i = 1'b1;
    logic        src_valid_i = 1'b0;
    logic [15:0] src_data_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe_o;
    logic        wait_o;
    logic        wait_oe_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    burst_pacer dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ce_ni       (ce_ni),
        .oe_ni       (oe_ni),
        .rd_mode_i   (rd_mode_i),
        .hold_long_i (hold_long_i),
        .src_valid_i (src_valid_i),
        .src_data_i  (src_data_i),
        .dq_o        (dq_o),
        .dq_oe_o     (dq_oe_o),
        .wait_o      (wait_o),
        .wait_oe_o   (wait_oe_o)
    );

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        src_valid_i = 1'b0;
        repeat (3) tick();
        rst_ni = 1'b1;
        #1;
    endtask

    task automatic idle_ce();
        ce_ni = 1'b1;
        src_valid_i = 1'b0;
        tick();
    endtask

    // R12-style reset state, plus R4 and R7 with no word
    task automatic t_reset_state();
        ce_ni = 1'b1; oe_ni = 1'b1;
        do_reset();
        chk("R4 reset wait_oe", 16'(wait_oe_o), 16'd0);
        chk("R9 reset dq_oe", 16'(dq_oe_o), 16'd0);
        ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd0; #1;
        chk("R7 no word wait", 16'(wait_o), 16'd1);
        chk("R9 no word dq", dq_o, 16'h0000);
        idle_ce();
    endtask

    // R1, R8, R7: long hold with a fresh source word every cycle
    task automatic t_long_hold();
        hold_long_i = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd0;
        src_valid_i = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            src_data_i = 16'h1000 + 16'(i);
            tick();
            chk("R1/R8 long hold dq", dq_o, 16'h1000 + 16'((i % 2 == 1) ? i : i - 1));
            chk("R7 wait low with word", 16'(wait_o), 16'd0);
        end
        src_valid_i = 1'b0;
        tick();
        chk("R7 wait after hold end", 16'(wait_o), 16'd1);
        chk("R9 dq zero no word", dq_o, 16'h0000);
        idle_ce();
    endtask

    // R2: short hold, new word every cycle
    task automatic t_short_hold();
        hold_long_i = 1'b0; ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd1;
        src_valid_i = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            src_data_i = 16'h2000 + 16'(i);
            tick();
            chk("R2 short hold dq", dq_o, 16'h2000 + 16'(i));
        end
        src_valid_i = 1'b0;
        tick();
        chk("R7 wait after short stream", 16'(wait_o), 16'd1);
        idle_ce();
    endtask

    // R10: setting changed mid-burst is ignored
    task automatic t_mid_change();
        hold_long_i = 1'b0; ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd0;
        src_valid_i = 1'b1;
        src_data_i = 16'h3001;
        tick();
        chk("R10 first word", dq_o, 16'h3001);
        hold_long_i = 1'b1;
        for (int i = 2; i <= 4; i++) begin
            src_data_i = 16'h3000 + 16'(i);
            tick();
            chk("R10 hold unchanged mid burst", dq_o, 16'h3000 + 16'(i));
        end
        idle_ce();
    endtask

    // R3: chip enable low through reset, default long hold
    task automatic t_reset_default();
        hold_long_i = 1'b0; ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd0;
        do_reset();
        src_valid_i = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            src_data_i = 16'h4000 + 16'(i);
            tick();
            chk("R3 default long hold", dq_o, 16'h4000 + 16'((i % 2 == 1) ? i : i - 1));
        end
        idle_ce();
    endtask

    // R11, R4, R9: abort in the middle of a hold
    task automatic t_abort();
        hold_long_i = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0; rd_mode_i = 2'd0;
        src_valid_i = 1'b1; src_data_i = 16'h5001;
        tick();
        chk("R11 word before abort", dq_o, 16'h5001);
        ce_ni = 1'b1; src_valid_i = 1'b0;
        tick();
        chk("R4 abort wait_oe", 16'(wait_oe_o), 16'd0);
        chk("R9 abort dq_oe", 16'(dq_oe_o), 16'd0);
        chk("R9 abort dq", dq_o, 16'h0000);
        ce_ni = 1'b0; #1;
        chk("R11 re-enable wait", 16'(wait_o), 16'd1);
        chk("R11 re-enable dq", dq_o, 16'h0000);
        tick();
        chk("R11 word discarded", dq_o, 16'h0000);
        idle_ce();
    endtask

    // R4, R5, R6, R9: WAIT and bus drive over all kinds and enables
    task automatic t_wait_matrix();
        src_valid_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 3; c++) begin
                logic exp_woe, exp_w, exp_doe;
                rd_mode_i = 2'(k);
                ce_ni = (c == 0);
                oe_ni = (c != 2);
                #1;
                exp_doe = (c == 2);
                if (c == 0) begin
                    exp_woe = 1'b0; exp_w = 1'b0;
                end else if (c == 1) begin
                    exp_woe = (k >= 2); exp_w = 1'b0;
                end else begin
                    exp_woe = 1'b1; exp_w = (k < 2);
                end
                chk((c == 0) ? "R4 wait_oe" : (c == 1) ? "R5 wait_oe" : "R6 wait_oe",
                    16'(wait_oe_o), 16'(exp_woe));
                chk((c == 2) ? "R6 wait value" : "R5 wait value", 16'(wait_o), 16'(exp_w));
                chk("R9 dq_oe", 16'(dq_oe_o), 16'(exp_doe));
            end
        end
        // async kind with a word present: WAIT stays low, bus carries word
        ce_ni = 1'b1; tick();
        rd_mode_i = 2'd2; ce_ni = 1'b0; oe_ni = 1'b0; hold_long_i = 1'b1;
        src_valid_i = 1'b1; src_data_i = 16'h6001;
        tick();
        chk("R6 async wait low", 16'(wait_o), 16'd0);
        chk("R6 async dq", dq_o, 16'h6001);
        oe_ni = 1'b1; #1;
        chk("R9 oe high dq released", dq_o, 16'h0000);
        oe_ni = 1'b0;
        idle_ce();
    endtask

    initial begin
        #(200_000 * 10);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_long_hold();
        t_short_hold();
        t_mid_change();
        t_reset_default();
        t_abort();
        t_wait_matrix();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule